// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits in a PCI host bridge. It turns one configuration read or write request from the host side into the configuration cycles needed on the PCI side. A request carries a bus number, a device/function number, a register offset, an access size and, for writes, write data. The block:

- maps device 0 of bus 0 onto IDSEL AD16;
- sends a reserved bus code to the bridge's own header;
- drops requests outside the supported bus and slot range;
- rejects misaligned accesses;
- builds the configuration window address.

Before each issued cycle it writes the bus number into a field of its control/status register.

Data is byte-swapped between the big-endian host and the little-endian PCI side. Byte and halfword reads pick their lane out of the aligned word. Byte and halfword writes are done as a read of the full word, a merge of the new lane, and a write of the full word. If the PCI side signals a master abort, a read returns all ones, the completion reports an abort, and a sticky timeout flag is set. Software clears that flag by writing 1 to it.

The block accepts one request at a time. It holds `busy` from acceptance until the one-cycle completion pulse.

The PCI side is a simple port. The block pulses a request. The PCI side answers with a response pulse, read data and an abort flag, at least one cycle after the request.

Top module: `pci_cfg_xlate`

## Requirements
- R1: An issued cycle uses the address WIN_BASE OR (effective device/function shifted left by 8) OR (offset AND 0xFC). Address bits 1:0 are always zero.
- R2: On bus 0 the effective device/function is the requested value plus 48, so device 0 lands on AD16. On buses 1 to 15 it is the requested value unchanged.
- R3: Bus code 256 addresses the bridge itself. Its effective bus and effective device/function are both 0, and the range check of R7 does not apply to it.
- R4: When a cycle is issued, the block writes the low 4 bits of the effective bus into control/status bits 26:23 and leaves every other bit unchanged. A request that is not issued leaves the field untouched.
- R5: If a response carries the abort flag, the completion status is 2. A read then returns 0xFFFFFFFF whatever its size, and control/status bit 8 is set.
- R6: Bit 8 stays set until a control/status write has data bit 8 equal to 1. A write with data bit 8 equal to 0 leaves it alone. All other bits take the written value.
- R7: A request whose bus is above 15, or whose slot (device/function bits 7:3) is above 15, is not issued. It completes with status 0. A read of this kind returns 0xFFFFFFFF, and a write of this kind makes no PCI cycle.
- R8: The size codes are 0 for a byte, 1 for a halfword and 2 for a word. Code 3, a halfword at an odd offset, or a word at an offset with bits 1:0 not both zero completes with status 1, read data 0 and no PCI cycle.
- R9: The host value equals the PCI word with its four bytes reversed. A word read returns the reversed response word, and a word write sends the reversed write data.
- R10: A byte or halfword read returns (host value >> 8 × offset[1:0]) masked to 8 or 16 bits.
- R11: A byte or halfword write makes one read and then one write to the same address. The written word is the reversed merge of the new lane into the host value. If the read aborts, no write follows.
- R12: Requests are accepted only while `busy` is low. `busy` stays high until `doneValid` pulses for exactly one cycle, and each accepted request produces exactly one completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBus | input | 9 | Bus number; 256 selects the bridge itself |
| reqDevFn | input | 8 | Device/function number |
| reqOffset | input | 8 | Register offset in bytes |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqWdata | input | 32 | Write data, right-aligned for narrow writes |
| busy | output | 1 | Request in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | 0 ok, 1 alignment/size error, 2 master abort |
| doneRdata | output | 32 | Read result, valid with doneValid |
| csrWrite | input | 1 | Control/status register write strobe |
| csrWdata | input | 32 | Control/status write data |
| csrRdata | output | 32 | Control/status register value |
| pciReqValid | output | 1 | Configuration cycle request pulse |
| pciReqWrite | output | 1 | Cycle is a write |
| pciAddr | output | 32 | Configuration cycle address |
| pciWdata | output | 32 | Write data in PCI byte order |
| pciRspValid | input | 1 | Response pulse |
| pciRspAbort | input | 1 | Response ended in master abort |
| pciRspData | input | 32 | Read data in PCI byte order |

## Verification
The bench builds the block with its defaults:

- a 9-bit bus input with self code 256;
- 8-bit device/function and offset;
- a 32-bit word;
- window base 0x8001_0000.

With these values, device/function bits 7:3 show up directly in address bits 15:11. The PCI model can therefore abort on one effective slot and return data computed from the address.

The sweep crosses these inputs:

- buses 0, 1, 9, 15, 16 and the self code;
- slots at 0, 1, 7, 15 and 16;
- offsets covering every lane plus high offsets;
- all four size codes, both directions.

This reaches both sides of the range limits, the bus-0 slot shift that turns slot 1 into the aborting slot, every lane shift and merge, and the abort path of a narrow write.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_ALIGN = 2'd1;
  localparam logic [1:0] ST_ABORT = 2'd2;

  // control -> datapath strobes
  typedef struct packed {
    logic latch;     // take a new request
    logic issue;     // request goes to the PCI side; update bus field
    logic capRead;   // good read response: extract or merge
    logic capAbort;  // response carried an abort
  } strobe_t;

  // datapath -> control decode
  typedef struct packed {
    logic skip;      // out of range, not issued
    logic reject;    // size/alignment error
    logic narrow;    // byte or halfword
    logic wrIn;      // incoming request is a write
    logic isWrite;   // latched request is a write
  } decode_t;

endpackage

// File: rtl/pci_cfg_ctrl.sv
module pci_cfg_ctrl
  import pci_cfg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  decode_t dec,
  input  logic    pciRspValid,
  input  logic    pciRspAbort,
  output strobe_t st,
  output logic    busy,
  output logic    doneValid,
  output logic    pciReqValid,
  output logic    pciReqWrite
);

  typedef enum logic [2:0] {
    S_IDLE, S_RDREQ, S_RDWAIT, S_WRREQ, S_WRWAIT, S_DONE
  } state_e;

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    st  = '0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          st.latch = 1'b1;
          if (dec.skip || dec.reject) begin
            nxt = S_DONE;
          end else begin
            st.issue = 1'b1;
            nxt = (dec.wrIn && !dec.narrow) ? S_WRREQ : S_RDREQ;
          end
        end
      end
      S_RDREQ:  nxt = S_RDWAIT;
      S_RDWAIT: begin
        if (pciRspValid) begin
          if (pciRspAbort) begin
            st.capAbort = 1'b1;
            nxt = S_DONE;
          end else begin
            st.capRead = 1'b1;
            nxt = dec.isWrite ? S_WRREQ : S_DONE;
          end
        end
      end
      S_WRREQ:  nxt = S_WRWAIT;
      S_WRWAIT: begin
        if (pciRspValid) begin
          st.capAbort = pciRspAbort;
          nxt = S_DONE;
        end
      end
      S_DONE:   nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  assign busy        = (state != S_IDLE);
  assign doneValid   = (state == S_DONE);
  assign pciReqValid = (state == S_RDREQ) || (state == S_WRREQ);
  assign pciReqWrite = (state == S_WRREQ);

endmodule

// File: rtl/pci_cfg_dpath.sv
module pci_cfg_dpath
  import pci_cfg_pkg::*;
#(
  parameter int          BUS_W    = 9,
  parameter int          DEVFN_W  = 8,
  parameter int          OFS_W    = 8,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h8001_0000,
  parameter int          SELF_BUS = 256,
  parameter int          BUS0_ADD = 48,
  parameter int          MAX_ID   = 15,
  parameter int          BUSF_LSB = 23,
  parameter int          BUSF_W   = 4,
  parameter int          TO_BIT   = 8
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqWrite,
  input  logic [BUS_W-1:0]   reqBus,
  input  logic [DEVFN_W-1:0] reqDevFn,
  input  logic [OFS_W-1:0]   reqOffset,
  input  logic [1:0]         reqSize,
  input  logic [DATA_W-1:0]  reqWdata,
  input  strobe_t            st,
  output decode_t            dec,
  output logic [1:0]         doneStatus,
  output logic [DATA_W-1:0]  doneRdata,
  input  logic               csrWrite,
  input  logic [DATA_W-1:0]  csrWdata,
  output logic [DATA_W-1:0]  csrRdata,
  output logic [ADDR_W-1:0]  pciAddr,
  output logic [DATA_W-1:0]  pciWdata,
  input  logic [DATA_W-1:0]  pciRspData
);

  localparam int NBYTES = DATA_W / 8;
  localparam int SLOT_W = DEVFN_W - 3;
  localparam logic [DATA_W-1:0] TO_MASK = DATA_W'(1) << TO_BIT;

  // ---------------- request decode ----------------
  logic               selfSel;
  logic [BUSF_W-1:0]  effBusLow;
  logic [DEVFN_W-1:0] effDevFn;
  logic [SLOT_W-1:0]  slotIn;
  logic               skipIn, badAlign, rejectIn;

  assign selfSel   = (reqBus == BUS_W'(SELF_BUS));
  assign effBusLow = selfSel ? '0 : reqBus[BUSF_W-1:0];
  assign slotIn    = reqDevFn[DEVFN_W-1:3];

  always_comb begin
    if (selfSel)                 effDevFn = '0;
    else if (reqBus == '0)       effDevFn = reqDevFn + DEVFN_W'(BUS0_ADD);
    else                         effDevFn = reqDevFn;
  end

  assign skipIn = !selfSel &&
                  ((reqBus > BUS_W'(MAX_ID)) || (slotIn > SLOT_W'(MAX_ID)));

  always_comb begin
    case (reqSize)
      SZ_BYTE: badAlign = 1'b0;
      SZ_HALF: badAlign = reqOffset[0];
      SZ_WORD: badAlign = |reqOffset[1:0];
      default: badAlign = 1'b1;
    endcase
  end

  assign rejectIn = !skipIn && badAlign;

  // ---------------- latched request ----------------
  logic               wrR;
  logic [DEVFN_W-1:0] devFnR;
  logic [OFS_W-1:0]   offR;
  logic [1:0]         sizeR;
  logic [DATA_W-1:0]  wdataR, wordR, rdataR;
  logic [1:0]         statusR;
  logic [DATA_W-1:0]  csrR, csrNext;

  assign dec.skip    = skipIn;
  assign dec.reject  = rejectIn;
  assign dec.narrow  = (reqSize == SZ_BYTE) || (reqSize == SZ_HALF);
  assign dec.wrIn    = reqWrite;
  assign dec.isWrite = wrR;

  // ---------------- byte order ----------------
  logic [DATA_W-1:0] rspHost;

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign rspHost[8*b +: 8]  = pciRspData[DATA_W-8-8*b +: 8];
    assign pciWdata[8*b +: 8] = wordR[DATA_W-8-8*b +: 8];
  end

  // ---------------- lane handling ----------------
  logic [4:0]        laneShift;
  logic [DATA_W-1:0] sizeMask, laneOut, mergeWord;

  assign laneShift = {offR[1:0], 3'b000};

  always_comb begin
    case (sizeR)
      SZ_BYTE: sizeMask = DATA_W'(8'hFF);
      SZ_HALF: sizeMask = DATA_W'(16'hFFFF);
      default: sizeMask = '1;
    endcase
  end

  assign laneOut   = (rspHost >> laneShift) & sizeMask;
  assign mergeWord = (rspHost & ~(sizeMask << laneShift)) |
                     ((wdataR & sizeMask) << laneShift);

  // ---------------- address ----------------
  assign pciAddr = ADDR_W'(WIN_BASE) |
                   (ADDR_W'(devFnR) << 8) |
                   ADDR_W'({offR[OFS_W-1:2], 2'b00});

  // ---------------- control/status register ----------------
  always_comb begin
    csrNext = csrR;
    if (csrWrite)
      csrNext = (csrWdata & ~TO_MASK) | (csrR & TO_MASK & ~csrWdata);
    if (st.issue)
      csrNext[BUSF_LSB +: BUSF_W] = effBusLow;
    if (st.capAbort)
      csrNext[TO_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrR     <= 1'b0;
      devFnR  <= '0;
      offR    <= '0;
      sizeR   <= SZ_WORD;
      wdataR  <= '0;
      wordR   <= '0;
      rdataR  <= '0;
      statusR <= ST_OK;
      csrR    <= '0;
    end else begin
      csrR <= csrNext;
      if (st.latch) begin
        wrR     <= reqWrite;
        devFnR  <= effDevFn;
        offR    <= reqOffset;
        sizeR   <= reqSize;
        wdataR  <= reqWdata;
        wordR   <= reqWdata;
        statusR <= rejectIn ? ST_ALIGN : ST_OK;
        rdataR  <= (skipIn && !reqWrite) ? '1 : '0;
      end
      if (st.capRead) begin
        if (wrR) wordR  <= mergeWord;
        else     rdataR <= laneOut;
      end
      if (st.capAbort) begin
        rdataR  <= '1;
        statusR <= ST_ABORT;
      end
    end
  end

  assign doneStatus = statusR;
  assign doneRdata  = rdataR;
  assign csrRdata   = csrR;

endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
  import pci_cfg_pkg::*;
#(
  parameter int          BUS_W    = 9,
  parameter int          DEVFN_W  = 8,
  parameter int          OFS_W    = 8,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h8001_0000,
  parameter int          SELF_BUS = 256,
  parameter int          BUS0_ADD = 48,
  parameter int          MAX_ID   = 15,
  parameter int          BUSF_LSB = 23,
  parameter int          BUSF_W   = 4,
  parameter int          TO_BIT   = 8
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [BUS_W-1:0]   reqBus,
  input  logic [DEVFN_W-1:0] reqDevFn,
  input  logic [OFS_W-1:0]   reqOffset,
  input  logic [1:0]         reqSize,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               busy,
  output logic               doneValid,
  output logic [1:0]         doneStatus,
  output logic [DATA_W-1:0]  doneRdata,
  input  logic               csrWrite,
  input  logic [DATA_W-1:0]  csrWdata,
  output logic [DATA_W-1:0]  csrRdata,
  output logic               pciReqValid,
  output logic               pciReqWrite,
  output logic [ADDR_W-1:0]  pciAddr,
  output logic [DATA_W-1:0]  pciWdata,
  input  logic               pciRspValid,
  input  logic               pciRspAbort,
  input  logic [DATA_W-1:0]  pciRspData
);

  strobe_t st;
  decode_t dec;

  pci_cfg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .dec         (dec),
    .pciRspValid (pciRspValid),
    .pciRspAbort (pciRspAbort),
    .st          (st),
    .busy        (busy),
    .doneValid   (doneValid),
    .pciReqValid (pciReqValid),
    .pciReqWrite (pciReqWrite)
  );

  pci_cfg_dpath #(
    .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .OFS_W(OFS_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SELF_BUS(SELF_BUS),
    .BUS0_ADD(BUS0_ADD), .MAX_ID(MAX_ID), .BUSF_LSB(BUSF_LSB),
    .BUSF_W(BUSF_W), .TO_BIT(TO_BIT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .reqWrite   (reqWrite),
    .reqBus     (reqBus),
    .reqDevFn   (reqDevFn),
    .reqOffset  (reqOffset),
    .reqSize    (reqSize),
    .reqWdata   (reqWdata),
    .st         (st),
    .dec        (dec),
    .doneStatus (doneStatus),
    .doneRdata  (doneRdata),
    .csrWrite   (csrWrite),
    .csrWdata   (csrWdata),
    .csrRdata   (csrRdata),
    .pciAddr    (pciAddr),
    .pciWdata   (pciWdata),
    .pciRspData (pciRspData)
  );

endmodule

// File: rtl/pci_cfg_xlate_chk.sv
module pci_cfg_xlate_chk #(
  parameter int DATA_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              doneValid,
  input logic [1:0]        doneStatus,
  input logic [DATA_W-1:0] doneRdata,
  input logic              pciReqValid,
  input logic              pciRspValid,
  input logic              pciRspAbort,
  input logic              csrWrite,
  input logic              clrTo,
  input logic              toFlag
);

  AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus == 2'd2) |-> (doneRdata == '1)); // R5

  AST_ABORT_SETS_TO: assert property (@(posedge clk) disable iff (!rstN)
    (busy && pciRspValid && pciRspAbort) |=> toFlag); // R5

  AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (toFlag && !(csrWrite && clrTo)) |=> toFlag); // R6

  AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrite && clrTo && !(busy && pciRspValid && pciRspAbort)) |=> !toFlag); // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!busy && !doneValid)); // R12

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pciReqValid |=> !pciReqValid); // R11

endmodule

bind pci_cfg_xlate pci_cfg_xlate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .doneValid   (doneValid),
  .doneStatus  (doneStatus),
  .doneRdata   (doneRdata),
  .pciReqValid (pciReqValid),
  .pciRspValid (pciRspValid),
  .pciRspAbort (pciRspAbort),
  .csrWrite    (csrWrite),
  .clrTo       (csrWdata[TO_BIT]),
  .toFlag      (csrRdata[TO_BIT])
);

// File: tb/pci_cfg_xlate_bench.sv
`timescale 1ns/1ps
module pci_cfg_xlate_bench;

  localparam logic [31:0] BASE = 32'h8001_0000;
  localparam logic [31:0] PAT  = 32'hA5C3_3C00;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [8:0]  reqBus = '0;
  logic [7:0]  reqDevFn = '0, reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        busy, doneValid;
  logic [1:0]  doneStatus;
  logic [31:0] doneRdata;
  logic        csrWrite = 1'b0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata;
  logic        pciReqValid, pciReqWrite;
  logic [31:0] pciAddr, pciWdata;
  logic        pciRspValid = 1'b0, pciRspAbort = 1'b0;
  logic [31:0] pciRspData = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pci_cfg_xlate u_pci_cfg_xlate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDevFn(reqDevFn), .reqOffset(reqOffset),
    .reqSize(reqSize), .reqWdata(reqWdata), .busy(busy),
    .doneValid(doneValid), .doneStatus(doneStatus), .doneRdata(doneRdata),
    .csrWrite(csrWrite), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .pciReqValid(pciReqValid), .pciReqWrite(pciReqWrite), .pciAddr(pciAddr),
    .pciWdata(pciWdata), .pciRspValid(pciRspValid), .pciRspAbort(pciRspAbort),
    .pciRspData(pciRspData)
  );

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] rdf(input logic [31:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8], ~a[7:0], a[15:8] ^ 8'hC5};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PCI side model: response two cycles after each request, abort on slot 7
  int          cnt = 0;
  int          nReq = 0, nWr = 0;
  logic [31:0] pendAddr = '0, lastRdAddr = '0, lastWrAddr = '0, lastWdata = '0;
  logic        pendWr = 1'b0;

  always @(negedge clk) begin
    pciRspValid = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        pciRspValid = 1'b1;
        pciRspAbort = (pendAddr[15:11] == 5'd7);
        pciRspData  = pendWr ? 32'h0 : rdf(pendAddr);
      end
    end
    if (pciReqValid) begin
      cnt = 2;
      pendAddr = pciAddr;
      pendWr = pciReqWrite;
      nReq++;
      if (pciReqWrite) begin
        nWr++;
        lastWrAddr = pciAddr;
        lastWdata = pciWdata;
      end else begin
        lastRdAddr = pciAddr;
      end
    end
  end

  logic [1:0]  gotStatus;
  logic [31:0] gotRdata;

  task automatic issueReq(input logic w, input logic [8:0] bus, input logic [7:0] df,
                          input logic [7:0] off, input logic [1:0] sz,
                          input logic [31:0] wd, input int holdCycles);
    int waitCnt;
    nReq = 0; nWr = 0;
    reqValid = 1'b1; reqWrite = w; reqBus = bus; reqDevFn = df;
    reqOffset = off; reqSize = sz; reqWdata = wd;
    repeat (holdCycles) @(negedge clk);
    reqValid = 1'b0;
    waitCnt = 0;
    while (!doneValid && waitCnt < 40) begin
      @(negedge clk);
      waitCnt++;
    end
    chk("R12 completion arrives", {31'd0, doneValid}, 32'd1);
    gotStatus = doneStatus;
    gotRdata = doneRdata;
    @(negedge clk);
    chk("R12 busy drops after completion", {31'd0, busy}, 32'd0);
  endtask

  task automatic runAcc(input logic w, input logic [8:0] bus, input logic [7:0] df,
                        input logic [7:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, input logic clr);
    logic        selfB, skip, reject, issued, abortE, narrow;
    logic [3:0]  effBus;
    logic [7:0]  effDf;
    logic [31:0] addr, mask, host, expRd, expWd, expCsr;
    logic [4:0]  sh;
    int          expReq;
    if (clr) begin
      @(negedge clk);
      csrWrite = 1'b1; csrWdata = PAT | 32'h100;
      @(negedge clk);
      csrWrite = 1'b0;
    end else begin
      @(negedge clk);
    end
    issueReq(w, bus, df, off, sz, wd, 1);

    selfB  = (bus == 9'd256);
    skip   = !selfB && (bus > 9'd15 || df[7:3] > 5'd15);
    effBus = selfB ? 4'd0 : bus[3:0];
    effDf  = selfB ? 8'd0 : ((bus == 9'd0) ? df + 8'd48 : df);
    reject = !skip && (sz == 2'd3 || (sz == 2'd2 && off[1:0] != 2'd0) ||
                       (sz == 2'd1 && off[0]));
    issued = !skip && !reject;
    narrow = (sz == 2'd0) || (sz == 2'd1);
    addr   = BASE | ({24'd0, effDf} << 8) | {24'd0, off & 8'hFC};
    abortE = issued && (addr[15:11] == 5'd7);
    mask   = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    sh     = {off[1:0], 3'b000};
    host   = bswap(rdf(addr));
    expReq = !issued ? 0 : ((w && narrow) ? (abortE ? 1 : 2) : 1);
    expRd  = skip ? 32'hFFFF_FFFF : reject ? 32'h0 : abortE ? 32'hFFFF_FFFF
           : ((host >> sh) & mask);
    expWd  = narrow ? bswap((host & ~(mask << sh)) | ((wd & mask) << sh)) : bswap(wd);

    if (reject)      chk("R8 status", {30'd0, gotStatus}, 32'd1);
    else if (abortE) chk("R5 status", {30'd0, gotStatus}, 32'd2);
    else             chk("R7 R9 status ok", {30'd0, gotStatus}, 32'd0);
    chk("R7 R8 R11 cycle count", nReq, expReq);
    if (issued && (!w || narrow))
      chk("R1 R2 R3 read address", lastRdAddr, addr);
    if (issued && w && !(narrow && abortE)) begin
      chk("R1 R2 R3 write address", lastWrAddr, addr);
      chk("R9 R11 write data", lastWdata, expWd);
    end
    if (!w) chk("R5 R7 R9 R10 read data", gotRdata, expRd);
    if (clr) begin
      expCsr = PAT;
      if (issued) expCsr[26:23] = effBus;
      if (abortE) expCsr[8] = 1'b1;
      chk("R4 R5 control/status", csrRdata, expCsr);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0]  busList [6];
    logic [7:0]  dfList  [5];
    logic [7:0]  offList [6];
    int          doneCount;
    busList = '{9'd0, 9'd1, 9'd9, 9'd15, 9'd16, 9'd256};
    dfList  = '{8'h00, 8'h0B, 8'h38, 8'h7F, 8'h80};
    offList = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h3E, 8'hFD};

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 reset busy", {31'd0, busy}, 32'd0);
    chk("R12 reset done", {31'd0, doneValid}, 32'd0);
    chk("R12 reset pci request", {31'd0, pciReqValid}, 32'd0);
    chk("R6 reset control/status", csrRdata, 32'd0);

    for (int bi = 0; bi < 6; bi++)
      for (int di = 0; di < 5; di++)
        for (int oi = 0; oi < 6; oi++)
          for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++)
              runAcc(w[0], busList[bi], dfList[di], offList[oi], s[1:0],
                     32'h1357_9BDF ^ {oi[7:0], di[7:0], bi[7:0], s[7:0]}, 1'b1);

    // R6: sticky timeout
    runAcc(1'b0, 9'd1, 8'h38, 8'h04, 2'd2, 32'h0, 1'b1);
    chk("R6 set after abort", {31'd0, csrRdata[8]}, 32'd1);
    runAcc(1'b0, 9'd1, 8'h08, 8'h04, 2'd2, 32'h0, 1'b0);
    chk("R6 kept over good access", {31'd0, csrRdata[8]}, 32'd1);
    @(negedge clk);
    csrWrite = 1'b1; csrWdata = 32'h0;
    @(negedge clk);
    csrWrite = 1'b0;
    @(negedge clk);
    chk("R6 kept on write of 0", {31'd0, csrRdata[8]}, 32'd1);
    chk("R6 other bits written", csrRdata & ~32'h100, 32'h0);
    csrWrite = 1'b1; csrWdata = 32'h100;
    @(negedge clk);
    csrWrite = 1'b0;
    @(negedge clk);
    chk("R6 cleared on write of 1", {31'd0, csrRdata[8]}, 32'd0);

    // R12: request held high while busy is ignored
    doneCount = 0;
    fork
      issueReq(1'b0, 9'd2, 8'h10, 8'h08, 2'd2, 32'h0, 3);
      begin
        repeat (30) begin
          @(negedge clk);
          if (doneValid) doneCount++;
        end
      end
    join
    chk("R12 single completion", doneCount, 1);
    chk("R12 single cycle", nReq, 1);
    chk("R12 status", {30'd0, gotStatus}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule